// File: doc/BRIEF.md
# Peripheral Bus DMA Controller

This block copies bytes between main DRAM and a peripheral bus. Software sets it up through a five-entry register window: a DRAM byte address, a peripheral byte address, two length registers (one per direction) and a status word. A write to a length register starts a transfer in that register's direction. The engine then moves one byte in each cycle where the source side offers data and the destination side accepts it.

The byte count comes from the length register and is adjusted by fixed rules. One is added to the programmed value, and an odd result is rounded up to even. The count is then shortened by the misalignment of the DRAM address within an 8-byte word. When the last byte has moved, both address registers step forward past the moved data and are rounded up. The DRAM address is rounded to a multiple of 8 and the peripheral address to a multiple of 2. Busy then drops and a level interrupt rises. Reading the registers back returns masked addresses and a fixed constant for both length registers.

Top module: `pbdma_top`

## Requirements
- R1: After reset both address registers hold zero, the status word reads 0 and `irq` is low.
- R2: Register offsets on `cfg_addr`: 0 DRAM address, 1 peripheral address, 2 read-length, 3 write-length, 4 status. Writing offset 2 starts a DRAM-to-peripheral transfer. Writing offset 3 starts a peripheral-to-DRAM transfer. Either write sets busy, which is status bit 0.
- R3: The base byte count is bits [23:0] of the written length value plus one, rounded up to the next even number when odd. Bits [31:24] have no effect.
- R4: The count is then reduced by the DRAM address bits [2:1] taken as a byte offset (0, 2, 4 or 6). Address bit 0 is ignored. A count that would go below zero becomes zero, and such a transfer completes with no bytes moved.
- R5: One byte moves per cycle, exactly when the source-ready and destination-ready inputs of the active direction are both high. The source byte appears on the destination data port in the same cycle. Only the enables of the active direction are asserted. The addresses driven are the base plus the byte index: the DRAM base is register bits [23:1] with bit 0 zero, and the peripheral base is register bits [27:1] with bit 0 zero.
- R6: On completion the DRAM address register becomes (old value + count + 7) with bits [2:0] cleared.
- R7: On completion the peripheral address register becomes (old value + count + 1) with bit 0 cleared.
- R8: In the cycle after the last byte moves, busy is clear and the interrupt flag (status bit 1) and `irq` are high. For a zero count this happens one cycle after the start.
- R9: Writing the status register with bit 1 set clears the interrupt flag and `irq`.
- R10: While busy, writes to the address and length registers are ignored and start nothing.
- R11: Readback: both length offsets return 0x7F. The DRAM address returns bits [23:1] with all other bits zero. The peripheral address returns bits [31:1] with bit 0 zero. Status returns {30'b0, irq, busy}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level interrupt |
| dram_addr | output | DRAM_AW | DRAM byte address |
| dram_rdata | input | 8 | Byte from DRAM |
| dram_rd_rdy | input | 1 | DRAM has a byte available |
| dram_rd_en | output | 1 | Byte taken from DRAM this cycle |
| dram_wdata | output | 8 | Byte to DRAM |
| dram_wr_rdy | input | 1 | DRAM can accept a byte |
| dram_wr_en | output | 1 | Byte written to DRAM this cycle |
| per_addr | output | PER_AW | Peripheral byte address |
| per_rdata | input | 8 | Byte from peripheral |
| per_rd_rdy | input | 1 | Peripheral has a byte available |
| per_rd_en | output | 1 | Byte taken from peripheral this cycle |
| per_wdata | output | 8 | Byte to peripheral |
| per_wr_rdy | input | 1 | Peripheral can accept a byte |
| per_wr_en | output | 1 | Byte written to peripheral this cycle |

## Verification
The bench aims at the corners of the count arithmetic. These are odd lengths, which a design without rounding would cut one byte short. They also include DRAM offsets of 6 against a minimum count of 2, where a design without the clamp would wrap and run for millions of cycles. Stray upper bits in the length value are tried too, since a design that kept them would produce enormous counts. Post-completion addresses are checked across random bases, so rounding applied before the add or to the wrong granule shows up in readback. Writes made during a stalled transfer must leave the readback and the byte count unchanged; a design that accepted them would move the wrong number of bytes.

// File: rtl/pbdma_pkg.sv
package pbdma_pkg;
  localparam int LEN_W = 24;
  localparam int CNT_W = LEN_W + 1;

  localparam logic [2:0] A_DRAM  = 3'd0;
  localparam logic [2:0] A_PER   = 3'd1;
  localparam logic [2:0] A_RDLEN = 3'd2;
  localparam logic [2:0] A_WRLEN = 3'd3;
  localparam logic [2:0] A_STAT  = 3'd4;

  localparam logic [31:0] LEN_READBACK = 32'h0000_007F;
  localparam int STAT_CLR_BIT = 1;

  function automatic logic [CNT_W-1:0] trim_len(input logic [LEN_W-1:0] lfield,
                                                input logic [2:0] dlow);
    logic [CNT_W-1:0] n;
    n = {1'b0, lfield} + 1'b1;
    if (n[0]) n = n + 1'b1;
    if (n > CNT_W'(dlow)) n = n - CNT_W'(dlow);
    else n = '0;
    return n;
  endfunction

  function automatic logic [31:0] dram_post(input logic [31:0] a, input logic [CNT_W-1:0] b);
    logic [31:0] s;
    s = a + 32'(b) + 32'd7;
    return {s[31:3], 3'b000};
  endfunction

  function automatic logic [31:0] per_post(input logic [31:0] a, input logic [CNT_W-1:0] b);
    logic [31:0] s;
    s = a + 32'(b) + 32'd1;
    return {s[31:1], 1'b0};
  endfunction
endpackage

// File: rtl/pbdma_mover.sv
module pbdma_mover
  import pbdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_len,
  input  logic             src_rdy,
  input  logic             dst_rdy,
  output logic             busy,
  output logic             move,
  output logic             done,
  output logic [CNT_W-1:0] offset,
  output logic [CNT_W-1:0] total
);
  logic [CNT_W-1:0] remain;
  logic             empty;

  assign empty = (remain == '0);
  assign move  = busy && !empty && src_rdy && dst_rdy;
  assign done  = busy && (empty || (move && remain == CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
      offset <= '0;
      total  <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      remain <= start_len;
      offset <= '0;
      total  <= start_len;
    end else if (busy) begin
      if (move) begin
        remain <= remain - 1'b1;
        offset <= offset + 1'b1;
      end
      if (done) busy <= 1'b0;
    end
  end

  // R5: bytes moved plus bytes left always equals the loaded count
  a_r5_count_track: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (offset + remain == total));
  // R8: completion always drops busy on the next edge
  a_r8_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R2: an accepted start raises busy
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/pbdma_regs.sv
module pbdma_regs
  import pbdma_pkg::*;
#(
  parameter int DRAM_AW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic [CNT_W-1:0] total,
  output logic             start,
  output logic [CNT_W-1:0] start_len,
  output logic             to_per,
  output logic [31:0]      dram_reg,
  output logic [31:0]      per_reg,
  output logic             irq
);
  logic sel_len, irq_clr;

  assign sel_len   = (cfg_addr == A_RDLEN) || (cfg_addr == A_WRLEN);
  assign start     = cfg_we && !busy && sel_len;
  assign start_len = trim_len(cfg_wdata[LEN_W-1:0], {dram_reg[2:1], 1'b0});
  assign irq_clr   = cfg_we && (cfg_addr == A_STAT) && cfg_wdata[STAT_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_reg <= '0;
      per_reg  <= '0;
      to_per   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (cfg_we && !busy && cfg_addr == A_DRAM) dram_reg <= cfg_wdata;
      if (cfg_we && !busy && cfg_addr == A_PER)  per_reg  <= cfg_wdata;
      if (start) to_per <= (cfg_addr == A_RDLEN);
      if (irq_clr) irq <= 1'b0;
      if (done) begin
        dram_reg <= dram_post(dram_reg, total);
        per_reg  <= per_post(per_reg, total);
        irq      <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (cfg_addr)
      A_DRAM:           cfg_rdata = 32'({dram_reg[DRAM_AW-1:1], 1'b0});
      A_PER:            cfg_rdata = {per_reg[31:1], 1'b0};
      A_RDLEN, A_WRLEN: cfg_rdata = LEN_READBACK;
      A_STAT:           cfg_rdata = {30'b0, irq, busy};
      default:          cfg_rdata = '0;
    endcase
  end

  // R10: a busy engine keeps its DRAM address despite writes
  a_r10_hold_dram: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we && cfg_addr == A_DRAM && !done) |=> (dram_reg == $past(dram_reg)));
  // R8: completion raises the interrupt
  a_r8_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq);
  // R6: DRAM address is 8-byte aligned after completion
  a_r6_dram_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (dram_reg[2:0] == 3'b000));
  // R7: peripheral address is even after completion
  a_r7_per_even: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !per_reg[0]);
  // R11: length offsets read the constant
  a_r11_len_const: assert property (@(posedge clk) disable iff (!rst_n)
    sel_len |-> (cfg_rdata == 32'h7F));
  // R9: a clear with no completion lowers the interrupt
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !done) |=> !irq);
endmodule

// File: rtl/pbdma_top.sv
module pbdma_top
  import pbdma_pkg::*;
#(
  parameter int DRAM_AW = 24,
  parameter int PER_AW  = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic               irq,
  output logic [DRAM_AW-1:0] dram_addr,
  input  logic [7:0]         dram_rdata,
  input  logic               dram_rd_rdy,
  output logic               dram_rd_en,
  output logic [7:0]         dram_wdata,
  input  logic               dram_wr_rdy,
  output logic               dram_wr_en,
  output logic [PER_AW-1:0]  per_addr,
  input  logic [7:0]         per_rdata,
  input  logic               per_rd_rdy,
  output logic               per_rd_en,
  output logic [7:0]         per_wdata,
  input  logic               per_wr_rdy,
  output logic               per_wr_en
);
  logic             start, busy, move, done, to_per, src_rdy, dst_rdy;
  logic [CNT_W-1:0] start_len, offset, total;
  logic [31:0]      dram_reg, per_reg;

  pbdma_regs #(.DRAM_AW(DRAM_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .done(done),
    .total(total), .start(start), .start_len(start_len), .to_per(to_per),
    .dram_reg(dram_reg), .per_reg(per_reg), .irq(irq)
  );

  assign src_rdy = to_per ? dram_rd_rdy : per_rd_rdy;
  assign dst_rdy = to_per ? per_wr_rdy  : dram_wr_rdy;

  pbdma_mover u_mover (
    .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
    .src_rdy(src_rdy), .dst_rdy(dst_rdy), .busy(busy), .move(move),
    .done(done), .offset(offset), .total(total)
  );

  assign dram_addr  = {dram_reg[DRAM_AW-1:1], 1'b0} + DRAM_AW'(offset);
  assign per_addr   = {per_reg[PER_AW-1:1], 1'b0} + PER_AW'(offset);
  assign dram_rd_en = move && to_per;
  assign per_wr_en  = move && to_per;
  assign per_rd_en  = move && !to_per;
  assign dram_wr_en = move && !to_per;
  assign per_wdata  = dram_rdata;
  assign dram_wdata = per_rdata;

  // R5: at most one direction is active on each side
  a_r5_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dram_rd_en, dram_wr_en}) && $onehot0({per_rd_en, per_wr_en}));
  // R5: no byte moves while idle
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(dram_rd_en || dram_wr_en || per_rd_en || per_wr_en));
endmodule

// File: tb/tb_pbdma_top.sv
module tb_pbdma_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq;
  logic [23:0] dram_addr;
  logic [7:0]  dram_rdata = '0, dram_wdata, per_rdata = '0, per_wdata;
  logic        dram_rd_rdy = 0, dram_wr_rdy = 0, per_rd_rdy = 0, per_wr_rdy = 0;
  logic        dram_rd_en, dram_wr_en, per_rd_en, per_wr_en;
  logic [27:0] per_addr;

  int nchk = 0, nerr = 0, cyc = 0;
  bit ended = 0;
  logic [31:0] m_dram = 0, m_per = 0;

  always #10 clk = ~clk;

  pbdma_top dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_len(logic [31:0] lreg, logic [31:0] dreg);
    int l, lo;
    l = int'(lreg & 32'h00FF_FFFF) + 1;
    l = l + (l % 2);
    lo = int'(dreg & 32'h6);
    return (l > lo) ? l - lo : 0;
  endfunction

  function automatic logic [31:0] up_to(logic [31:0] a, int n, int g);
    logic [31:0] s;
    s = a + 32'(n) + 32'(g - 1);
    return (s / 32'(g)) * 32'(g);
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic run_xfer(logic [31:0] dreg, logic [31:0] preg, logic [31:0] lreg,
                          bit to_per, bit stall);
    int L, idx;
    logic [31:0] v;
    bit s, d, mv;
    wr(3'd0, dreg);
    wr(3'd1, preg);
    m_dram = dreg; m_per = preg;
    L = exp_len(lreg, dreg);
    wr(to_per ? 3'd2 : 3'd3, lreg);
    rd(3'd4, v);
    chk("R2 busy after start", v & 32'h1, 32'h1);
    if (stall) begin
      wr(3'd0, ~dreg);
      wr(3'd1, ~preg);
      wr(3'd3, 32'h0000_0100);
      rd(3'd0, v);
      chk("R10 dram addr held", v, dreg & 32'h00FF_FFFE);
      rd(3'd1, v);
      chk("R10 per addr held", v, preg & 32'hFFFF_FFFE);
      rd(3'd4, v);
      chk("R10 still busy", v & 32'h1, (L > 0) ? 32'h1 : 32'h0);
    end
    idx = 0;
    while (idx < L) begin
      s = ($urandom % 4) != 0;
      d = ($urandom % 4) != 0;
      dram_rdata = 8'($urandom);
      per_rdata  = 8'($urandom);
      if (to_per) begin dram_rd_rdy = s; per_wr_rdy = d; per_rd_rdy = $urandom; dram_wr_rdy = $urandom; end
      else        begin per_rd_rdy = s; dram_wr_rdy = d; dram_rd_rdy = $urandom; per_wr_rdy = $urandom; end
      #1;
      mv = s && d;
      chk("R5 enables", {dram_rd_en, dram_wr_en, per_rd_en, per_wr_en},
          {mv && to_per, mv && !to_per, mv && !to_per, mv && to_per});
      if (mv) begin
        chk("R5 dram addr", 32'(dram_addr), ((dreg & 32'h00FF_FFFE) + 32'(idx)) & 32'h00FF_FFFF);
        chk("R5 per addr", 32'(per_addr), ((preg & 32'h0FFF_FFFE) + 32'(idx)) & 32'h0FFF_FFFF);
        chk("R5 data", to_per ? 32'(per_wdata) : 32'(dram_wdata),
            to_per ? 32'(dram_rdata) : 32'(per_rdata));
      end
      @(posedge clk);
      if (mv) idx++;
      if (idx < L) begin
        @(negedge clk);
        rd(3'd4, v);
        chk("R3 not finished early", v & 32'h1, 32'h1);
      end else @(negedge clk);
    end
    dram_rd_rdy = 0; dram_wr_rdy = 0; per_rd_rdy = 0; per_wr_rdy = 0;
    if (L == 0) @(negedge clk);
    rd(3'd4, v);
    chk("R8 status after done", v, 32'h2);
    chk("R8 irq pin", 32'(irq), 32'h1);
    m_dram = up_to(m_dram, L, 8);
    m_per  = up_to(m_per, L, 2);
    rd(3'd0, v);
    chk("R6 dram post address", v, m_dram & 32'h00FF_FFFE);
    rd(3'd1, v);
    chk("R7 per post address", v, m_per & 32'hFFFF_FFFE);
    rd(3'd2, v);
    chk("R11 rd length readback", v, 32'h7F);
    rd(3'd3, v);
    chk("R11 wr length readback", v, 32'h7F);
    wr(3'd4, 32'h2);
    #1;
    chk("R9 irq cleared", 32'(irq), 32'h0);
    rd(3'd4, v);
    chk("R9 status cleared", v, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !ended) begin
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
        ended = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, v); chk("R1 dram reset", v, 32'h0);
    rd(3'd1, v); chk("R1 per reset", v, 32'h0);
    rd(3'd4, v); chk("R1 status reset", v, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R11 dram readback mask", v, 32'h00FF_FFFE);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R11 per readback mask", v, 32'hFFFF_FFFE);
    // directed corners
    run_xfer(32'h0000_1000, 32'h1000_0000, 32'h0, 1, 0);          // R3 length 1 -> 2
    run_xfer(32'h0000_1006, 32'h1000_0003, 32'h1, 0, 0);          // R4 clamp to zero
    run_xfer(32'h0000_1007, 32'h1000_0001, 32'h0000_0008, 1, 0); // R4 odd 9->10 minus 6
    run_xfer(32'h0000_2003, 32'h1000_0010, 32'hFF00_0004, 0, 0); // R3 upper bits ignored
    run_xfer(32'hABFF_FFFA, 32'hFFFF_FFF0, 32'h0000_0013, 1, 1); // R10 stall, wrap
    run_xfer(32'h0000_3002, 32'h1000_0020, 32'h0000_000B, 0, 1); // R10 stall other dir
    for (int i = 0; i < 40; i++)
      run_xfer($urandom, $urandom, {8'($urandom), 16'h0, 8'($urandom % 40)},
               1'($urandom), ($urandom % 5) == 0);
    ended = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule